// File: doc/BRIEF.md
# Serial Peripheral Master with Queue-Fed Transmit

This block is a serial peripheral (SPI) bus master that runs entirely on the system clock. The serial clock is not a separate clock net. It is a register that toggles whenever a programmable half-period counter expires, so its rate and idle level can be changed at runtime without touching the clock tree. Outgoing bytes come from a first-word-fall-through queue: the head byte is presented with an empty flag, and the master pops it. Each received byte leaves on a data bus with a one-cycle valid strobe.

Four inputs configure a transfer: clock polarity, clock phase, a divider value and a target-slave index. They are captured when a burst begins. Bytes keep flowing with the chosen select held low while the queue has data, and the burst closes at a byte boundary once the queue runs dry. If any configuration input moves while a burst is in progress, a sticky error flag rises. The burst itself finishes with the captured settings.

Top module: `spi_fifo_master`

## Requirements
- R1: Within a byte, consecutive serial-clock transitions are exactly `cfg_div + 1` system clocks apart, for every divider value from 0 up to the maximum `2**DIV_W - 1`.
- R2: Outside a burst, `sclk` rests at the level of `cfg_cpol` and makes no transitions.
- R3: The selected `ss_n` line falls `cfg_div + 1` clocks before the first serial-clock transition of a burst. It rises `cfg_div + 1` clocks after the last transition. Between two bytes of one burst, the gap from the last transition of one byte to the first transition of the next is `2*(cfg_div + 1)` clocks.
- R4: Bytes are 8 bits, most significant bit first, and each byte makes 16 serial-clock transitions. The leading transition is the one that moves `sclk` away from `cfg_cpol`. With `cfg_cpha`=0, `mosi` carries bit 7 before the first transition, changes on trailing transitions, and is valid at every leading transition. With `cfg_cpha`=1, `mosi` changes on leading transitions and is valid at every trailing transition.
- R5: Each byte produces exactly one single-cycle `rx_valid` pulse. `rx_data` then holds the 8 bits seen on `miso`, most significant bit first, taken on leading transitions when `cfg_cpha`=0 and on trailing transitions when `cfg_cpha`=1.
- R6: `tx_pop` is asserted only while `tx_empty` is low, once per byte. While the queue holds data at a byte boundary, the select stays low and the next byte follows. When the queue is empty at a byte boundary, the select is released and the serial clock stops.
- R7: During a burst exactly one `ss_n` bit is low: bit `i` where `i` is the value of `cfg_slave`. All other bits stay high.
- R8: A change of any configuration input while the select is low sets `cfg_err` from the next cycle on. The flag holds until the next burst begins. The burst in progress completes with its captured settings.
- R9: While `rst` is high (from the first clock edge on), `sclk`, `mosi`, `rx_valid`, `rx_data` and `cfg_err` are 0, every `ss_n` bit is 1, and `tx_pop` is 0, whatever the other inputs do.
- R10: Configuration changes made while no burst is active never set `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Phase: 0 samples on leading transitions, 1 on trailing |
| cfg_div | input | DIV_W | Half-period length minus one, in system clocks |
| cfg_slave | input | SEL_W | Index of the select line to drive |
| tx_data | input | 8 | Head byte of the transmit queue |
| tx_empty | input | 1 | Transmit queue holds no byte |
| tx_pop | output | 1 | Consume the head byte this cycle |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SLAVES | Active-low slave selects |
| cfg_err | output | 1 | Sticky configuration-change error |

## Verification
The hardest state to reach from the ports is a configuration change that lands partway through a multi-byte burst. In that state the flag must rise while the shift timing keeps the captured divider. The bench reaches it by queueing three bytes before the master starts. It then counts clock cycles from the falling select and alters the divider in the middle of the first byte. A slave model watches every transition gap against the old divider and confirms that all three bytes still arrive intact. A full sweep over the four modes, four divider values including 0 and the maximum, and all four slave indices covers the timing and select rules.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL
    } spi_state_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
    } spi_mode_t;

    // Does this transition drive a new data bit out?
    function automatic logic drives_bit(input logic cpha, input logic leading,
                                        input logic last);
        return cpha ? leading : (!leading && !last);
    endfunction

    // Does this transition capture the incoming data line?
    function automatic logic takes_bit(input logic cpha, input logic leading);
        return cpha ? !leading : leading;
    endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_sel_decode.sv
module spi_sel_decode #(
    parameter int NUM_SLAVES = 4,
    parameter int SEL_W      = 2
) (
    input  logic [SEL_W-1:0]      sel,
    output logic [NUM_SLAVES-1:0] sel_n
);
    generate
        if (NUM_SLAVES == 1) begin : g_single
            logic unused_sel;
            assign unused_sel = ^sel;
            assign sel_n = 1'b0;
        end else begin : g_multi
            for (genvar i = 0; i < NUM_SLAVES; i++) begin : g_line
                assign sel_n[i] = (sel != SEL_W'(i));
            end
        end
    endgenerate
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
    import spi_master_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int EDGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              cpha,
    input  logic              edge_en,
    input  logic [EDGE_W-1:0] edge_idx,
    input  logic              miso,
    output logic              mosi,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid
);
    localparam int LAST_EDGE = 2 * BYTE_W - 1;

    logic [BYTE_W-1:0] tx_sh_q;
    logic [BYTE_W-1:0] rx_sh_q;
    logic              leading;
    logic              last;

    assign leading = !edge_idx[0];
    assign last    = (edge_idx == EDGE_W'(LAST_EDGE));

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh_q  <= '0;
            rx_sh_q  <= '0;
            mosi     <= 1'b0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (load) begin
                if (!cpha) begin
                    mosi    <= load_data[BYTE_W-1];
                    tx_sh_q <= load_data << 1;
                end else begin
                    tx_sh_q <= load_data;
                end
            end else if (edge_en) begin
                if (drives_bit(cpha, leading, last)) begin
                    mosi    <= tx_sh_q[BYTE_W-1];
                    tx_sh_q <= tx_sh_q << 1;
                end
                if (takes_bit(cpha, leading)) begin
                    rx_sh_q <= {rx_sh_q[BYTE_W-2:0], miso};
                end
                if (last) begin
                    rx_valid <= 1'b1;
                    rx_data  <= cpha ? {rx_sh_q[BYTE_W-2:0], miso} : rx_sh_q;
                end
            end
        end
    end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spi_master_pkg::*;
#(
    parameter int NUM_SLAVES = 4,
    parameter int DIV_W      = 4,
    parameter int SEL_W      = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_cpol,
    input  logic                  cfg_cpha,
    input  logic [DIV_W-1:0]      cfg_div,
    input  logic [SEL_W-1:0]      cfg_slave,
    input  logic [7:0]            tx_data,
    input  logic                  tx_empty,
    output logic                  tx_pop,
    output logic [7:0]            rx_data,
    output logic                  rx_valid,
    output logic                  sclk,
    output logic                  mosi,
    input  logic                  miso,
    output logic [NUM_SLAVES-1:0] ss_n,
    output logic                  cfg_err
);
    localparam int BYTE_W = 8;
    localparam int EDGES  = 2 * BYTE_W;
    localparam int EDGE_W = $clog2(EDGES);
    localparam int CFG_W  = 2 + DIV_W + SEL_W;

    spi_state_e            state_q;
    logic [CFG_W-1:0]      cfg_q;
    logic [CFG_W-1:0]      cfg_now;
    spi_mode_t             mode_q;
    logic [DIV_W-1:0]      div_q;
    logic [EDGE_W-1:0]     edge_q;
    logic [NUM_SLAVES-1:0] sel_n;
    logic                  active;
    logic                  tick;
    logic                  edge_en;
    logic [EDGE_W-1:0]     edge_idx;
    logic                  cpha_eff;

    assign cfg_now = {cfg_cpol, cfg_cpha, cfg_div, cfg_slave};
    assign mode_q  = spi_mode_t'(cfg_q[CFG_W-1 -: 2]);
    assign div_q   = cfg_q[SEL_W +: DIV_W];
    assign active  = (state_q != ST_IDLE);

    assign tx_pop = !rst && !tx_empty &&
                    ((state_q == ST_IDLE) || (state_q == ST_TRAIL && tick));

    assign edge_en  = tick && (state_q == ST_LEAD || state_q == ST_SHIFT);
    assign edge_idx = (state_q == ST_LEAD) ? '0 : edge_q;
    assign cpha_eff = (state_q == ST_IDLE) ? cfg_cpha : mode_q.cpha;

    spi_half_timer #(.DIV_W(DIV_W)) timer_i (
        .clk   (clk),
        .rst   (rst),
        .run   (active),
        .limit (div_q),
        .tick  (tick)
    );

    spi_sel_decode #(.NUM_SLAVES(NUM_SLAVES), .SEL_W(SEL_W)) dec_i (
        .sel   (cfg_slave),
        .sel_n (sel_n)
    );

    spi_bit_engine #(.BYTE_W(BYTE_W), .EDGE_W(EDGE_W)) eng_i (
        .clk       (clk),
        .rst       (rst),
        .load      (tx_pop),
        .load_data (tx_data),
        .cpha      (cpha_eff),
        .edge_en   (edge_en),
        .edge_idx  (edge_idx),
        .miso      (miso),
        .mosi      (mosi),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            edge_q  <= '0;
            sclk    <= 1'b0;
            ss_n    <= '1;
            cfg_err <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    sclk <= cfg_cpol;
                    if (!tx_empty) begin
                        cfg_q   <= cfg_now;
                        cfg_err <= 1'b0;
                        ss_n    <= sel_n;
                        state_q <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        sclk    <= ~sclk;
                        edge_q  <= EDGE_W'(1);
                        state_q <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        sclk <= ~sclk;
                        if (edge_q == EDGE_W'(EDGES - 1)) begin
                            state_q <= ST_TRAIL;
                        end else begin
                            edge_q <= edge_q + 1'b1;
                        end
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        if (!tx_empty) begin
                            state_q <= ST_LEAD;
                        end else begin
                            ss_n    <= '1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
            if (active && (cfg_now != cfg_q)) begin
                cfg_err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
    parameter int NUM_SLAVES = 4,
    parameter int DIV_W      = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic [DIV_W-1:0]      cfg_div,
    input logic                  tx_empty,
    input logic                  tx_pop,
    input logic                  rx_valid,
    input logic                  sclk,
    input logic                  mosi,
    input logic [NUM_SLAVES-1:0] ss_n,
    input logic                  cfg_err
);
    logic rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
    end

    // R7: never more than one select low
    assert_one_select_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ss_n));

    // R6: the queue is popped only when it holds a byte
    assert_pop_needs_data_R6: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> !tx_empty);

    // R5: receive strobe lasts one cycle
    assert_rx_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R8: divider moved while selected -> error next cycle
    assert_err_on_change_R8: assert property (@(posedge clk) disable iff (rst)
        ((ss_n != '1) && !$stable(cfg_div)) |=> cfg_err);

    // R9: outputs at defaults after a reset edge
    always_ff @(posedge clk) begin
        if (rst_seen_q) begin
            assert_reset_defaults_R9: assert (ss_n == '1 && !sclk && !mosi &&
                                              !rx_valid && !cfg_err);
        end
        if (rst) begin
            assert_no_pop_in_reset_R9: assert (!tx_pop);
        end
    end
endmodule

bind spi_fifo_master spi_fifo_master_chk #(
    .NUM_SLAVES (NUM_SLAVES),
    .DIV_W      (DIV_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .cfg_div  (cfg_div),
    .tx_empty (tx_empty),
    .tx_pop   (tx_pop),
    .rx_valid (rx_valid),
    .sclk     (sclk),
    .mosi     (mosi),
    .ss_n     (ss_n),
    .cfg_err  (cfg_err)
);

// File: tb/spi_fifo_master_tb_top.sv
module spi_fifo_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS         = 4;
    localparam int DW         = 4;
    localparam int SW         = 2;
    localparam int DMAX       = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic [DW-1:0] cfg_div = '0;
    logic [SW-1:0] cfg_slave = '0;
    logic [7:0]    tx_data;
    logic          tx_empty;
    logic          tx_pop;
    logic [7:0]    rx_data;
    logic          rx_valid;
    logic          sclk, mosi;
    logic          miso = 1'b0;
    logic [NS-1:0] ss_n;
    logic          cfg_err;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_fifo_master #(.NUM_SLAVES(NS), .DIV_W(DW)) dut_i (
        .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_div(cfg_div), .cfg_slave(cfg_slave), .tx_data(tx_data),
        .tx_empty(tx_empty), .tx_pop(tx_pop), .rx_data(rx_data),
        .rx_valid(rx_valid), .sclk(sclk), .mosi(mosi), .miso(miso),
        .ss_n(ss_n), .cfg_err(cfg_err)
    );

    // transmit queue model (first word falls through)
    logic [7:0] fmem [0:31];
    int wr_p = 0;
    int rd_p = 0;
    assign tx_empty = (wr_p == rd_p);
    assign tx_data  = fmem[rd_p % 32];
    always @(posedge clk) if (tx_pop) rd_p <= rd_p + 1;

    int checks = 0, fails = 0;
    int seed = 0;
    int d_e = 0, sel_e = 0;
    logic cpol_e = 0, cpha_e = 0;

    function automatic logic [7:0] resp_b(int i);
        return 8'(i * 53 + 166 + seed);
    endfunction
    function automatic logic [7:0] tx_b(int i);
        return 8'(i * 29 + 60 + seed * 7);
    endfunction

    // monitor and slave model
    int gap = 0, ecnt = 0, bitcnt = 0, sidx = 0, rx_cnt = 0;
    int falls = 0, rises = 0, bad_gap = 0, bad_lt = 0, bad_sel = 0;
    int idle_edges = 0, mosi_bad = 0, rx_bad = 0;
    int exp_gap;
    logic first_byte = 0, prev_act = 0, prev_sclk = 0, act, leading;
    logic [7:0] srx = '0;

    always @(negedge clk) begin
        act = (ss_n != '1);
        if (rst) begin
            prev_act  = 1'b0;
            prev_sclk = sclk;
        end else begin
            gap = gap + 1;
            if (act && !prev_act) begin
                falls++; gap = 0; ecnt = 0; bitcnt = 0; first_byte = 1;
                if (!cpha_e) miso = resp_b(sidx)[7];
            end
            if (act && ss_n != ~(NS'(1) << sel_e)) bad_sel++;
            if (sclk != prev_sclk) begin
                if (!act) idle_edges++;
                else begin
                    if (ecnt == 0 && first_byte) begin
                        if (gap != d_e + 1) bad_lt++;
                    end else begin
                        exp_gap = (ecnt == 0) ? 2 * (d_e + 1) : d_e + 1;
                        if (gap != exp_gap) bad_gap++;
                    end
                    gap = 0;
                    leading = (sclk != cpol_e);
                    if (cpha_e ? !leading : leading) begin
                        srx = {srx[6:0], mosi};
                        bitcnt++;
                        if (bitcnt == 8) begin
                            if (srx != tx_b(sidx)) mosi_bad++;
                            sidx++; bitcnt = 0;
                        end
                    end
                    if (cpha_e ? leading : !leading) miso = resp_b(sidx)[7 - bitcnt];
                    ecnt++;
                    if (ecnt == 16) begin ecnt = 0; first_byte = 0; end
                end
            end
            if (!act && prev_act) begin
                rises++;
                if (gap != d_e + 1) bad_lt++;
            end
            if (rx_valid) begin
                if (rx_data != resp_b(rx_cnt)) rx_bad++;
                rx_cnt++;
            end
            prev_act  = act;
            prev_sclk = sclk;
        end
    end

    task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    task automatic clear_mon();
        falls = 0; rises = 0; bad_gap = 0; bad_lt = 0; bad_sel = 0;
        idle_edges = 0; mosi_bad = 0; rx_bad = 0; rx_cnt = 0; sidx = 0;
    endtask

    task automatic setup(input logic pol, input logic pha, input int d, input int s);
        @(negedge clk);
        cfg_cpol = pol; cfg_cpha = pha; cfg_div = DW'(d); cfg_slave = SW'(s);
        cpol_e = pol; cpha_e = pha; d_e = d; sel_e = s;
        repeat (3) @(negedge clk);
        clear_mon();
    endtask

    task automatic push(input int n);
        for (int i = 0; i < n; i++) begin
            fmem[wr_p % 32] = tx_b(sidx + rx_cnt + (wr_p - rd_p) - rx_cnt + i - sidx + 0 + 0 + (i - i));
            wr_p++;
        end
    endtask

    task automatic push_idx(input int first, input int n);
        for (int i = 0; i < n; i++) begin
            fmem[wr_p % 32] = tx_b(first + i);
            wr_p++;
        end
    endtask

    task automatic wait_rises(input int n);
        int t = 0;
        while (rises < n && t < 20000) begin
            @(negedge clk);
            t++;
        end
        if (rises < n) chk(0, "R6 burst never ended", rises, n);
        repeat (4) @(negedge clk);
    endtask

    task automatic sweep_case(input int m, input int d, input int s);
        setup(m[1], m[0], d, s);
        seed = m * 64 + d * 4 + s;
        push_idx(0, 2);
        wait_rises(1);
        chk(bad_gap == 0, "R1 half-period", bad_gap, 0);
        chk(idle_edges == 0 && sclk == cpol_e, "R2 idle level", sclk, cpol_e);
        chk(bad_lt == 0, "R3 lead/trail", bad_lt, 0);
        chk(mosi_bad == 0 && sidx == 2, "R4 mosi bytes", sidx, 2);
        chk(rx_bad == 0 && rx_cnt == 2, "R5 rx bytes", rx_cnt, 2);
        chk(falls == 1 && rises == 1, "R6 back-to-back select", falls, 1);
        chk(bad_sel == 0, "R7 select line", bad_sel, 0);
        chk(cfg_err == 1'b0, "R10 no error", cfg_err, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        chk(sclk == 0 && mosi == 0 && rx_valid == 0, "R9 reset serial", {sclk, mosi, rx_valid}, 0);
        chk(ss_n == '1 && cfg_err == 0 && rx_data == 0, "R9 reset selects", ss_n, 15);
        rst = 1'b0;

        for (int m = 0; m < 4; m++)
            for (int di = 0; di < 4; di++)
                for (int s = 0; s < NS; s++)
                    sweep_case(m, (di == 3) ? DMAX : di, s);

        // queue runs dry: one byte, then silence, then a fresh burst
        setup(1'b1, 1'b1, 2, 3);
        seed = 900;
        push_idx(0, 1);
        wait_rises(1);
        repeat (40) @(negedge clk);
        chk(falls == 1 && idle_edges == 0 && rx_cnt == 1, "R6 halt on empty", falls * 100 + idle_edges, 100);
        push_idx(1, 1);
        wait_rises(2);
        chk(falls == 2 && rx_bad == 0 && mosi_bad == 0, "R6 new burst after empty", falls, 2);

        // configuration change inside a burst
        setup(1'b0, 1'b0, 3, 1);
        seed = 1000;
        push_idx(0, 3);
        while (falls == 0) @(negedge clk);
        repeat (6) @(negedge clk);
        cfg_div = DW'(7);
        repeat (2) @(negedge clk);
        chk(cfg_err == 1'b1, "R8 error raised", cfg_err, 1);
        wait_rises(1);
        chk(rx_cnt == 3 && rx_bad == 0 && bad_gap == 0, "R8 burst keeps captured div", rx_cnt * 10 + bad_gap, 30);
        chk(cfg_err == 1'b1, "R8 error held", cfg_err, 1);
        cfg_div = DW'(3);
        repeat (3) @(negedge clk);
        clear_mon();
        seed = 1001;
        push_idx(0, 1);
        wait_rises(1);
        chk(cfg_err == 1'b0, "R8 error cleared by new burst", cfg_err, 0);

        // idle changes
        cfg_slave = 2'd2; cfg_cpha = 1'b1; cfg_div = DW'(9);
        repeat (3) @(negedge clk);
        chk(cfg_err == 1'b0, "R10 idle change", cfg_err, 0);
        cfg_cpol = 1'b1;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b1, "R2 idle follows polarity", sclk, 1);

        // reset in the middle of a burst with inputs moving
        setup(1'b1, 1'b0, 4, 0);
        seed = 1100;
        push_idx(0, 3);
        while (falls == 0) @(negedge clk);
        repeat (20) @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            miso = ~miso;
            cfg_div = DW'(i);
            chk(sclk == 0 && mosi == 0 && rx_valid == 0 && tx_pop == 0, "R9 outputs held in reset",
                {sclk, mosi, rx_valid, tx_pop}, 0);
            chk(ss_n == '1 && cfg_err == 0 && rx_data == 0, "R9 selects held in reset", ss_n, 15);
        end
        wr_p = rd_p;
        @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk(ss_n == '1, "R6 empty queue after reset", ss_n, 15);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule